// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block merges up to 128 level-sensitive interrupt lines into one processor interrupt request. Software reaches it through a plain 32-bit register port: byte address, write strobe, write data, and a read data bus that reflects the addressed register in the same cycle. Sources are grouped in banks of 32. Each bank has separate write-one-to-set and write-one-to-clear addresses for its mask bits and for its software-raised interrupt bits.

A source is pending when its input line or its software bit is high. It is eligible when it is pending and unmasked. When no interrupt is outstanding, the block latches the number of the lowest-numbered eligible source into a sorted-number register and raises the request line. Both stay frozen until software writes the acknowledge bit. The next selection can then take place.

A priority threshold register can hold off new selections. A self-clearing soft reset brings all software-visible state back to its power-up values over a short fixed count. A status bit reports when the soft reset has finished.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Address 0x00 reads the revision: major number in bits [7:4], minor in bits [3:0] (default 2 and 1, so 0x21), all other bits zero.
- R2: After hardware reset every mask bit is 1, every software bit is 0, the threshold (address 0x68, low 8 bits) reads 0xFF, and `irq_out` is low.
- R3: Source n is pending when `irq_src[n]` or its software bit is 1. Only pending sources with mask bit 0 can be selected, and a masked source never raises `irq_out`.
- R4: With nothing outstanding and an eligible source present, the next clock edge latches the lowest-numbered eligible source. `irq_out` rises, and address 0x40 reads that number in bits [6:0] with bit 7 clear.
- R5: While a selection is outstanding, `irq_out` stays high and address 0x40 keeps its value, whatever the source lines, masks or software bits do.
- R6: Writing 1 to bit 0 of address 0x48 releases the selection at that edge. A new selection may follow on the next edge. While nothing is outstanding, address 0x40 reads 0x80 (spurious).
- R7: For bank b, a write to 0x88+0x20*b clears each mask bit whose write-data bit (source mod 32) is 1, and a write to 0x8C+0x20*b sets those mask bits. Zero bits have no effect. Both addresses read back the bank's mask.
- R8: For bank b, a write to 0x90+0x20*b sets and a write to 0x94+0x20*b clears software bits, with the same bit-per-source encoding. Both addresses read back the bank's software bits.
- R9: Every source has a fixed priority level of 0 and is selected only if the threshold is 0xFF or greater than 0. A threshold of 0 holds off all new selections, and any nonzero value lets them through.
- R10: Writing bit 1 set to address 0x10 starts a soft reset. It returns masks, software bits, threshold and selection to the R2 values and lasts 4 cycles. Bit 0 of address 0x14 reads 0 until the reset is done, then 1. Register writes during the reset are ignored.
- R11: A write to address 0x10 with bit 1 clear changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 128 | Level-sensitive interrupt lines, bit n is source n |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe, write takes effect at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The selection logic is exercised in several ways:
- Sources are driven by lines alone, by software bits alone, and by both.
- Three sources in different banks are released at once, which shows that the lowest number wins across bank boundaries.
- A selected line is dropped, and another source is unmasked, while the first selection is still outstanding. This separates a latched selection from a live one.
- A zero threshold is set against a nonzero, non-0xFF one, which shows that only zero holds off selection.
- A soft reset is issued with an interrupt outstanding and a write racing it. This shows both that state is cleared and that writes are ignored during the reset count.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_REV    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_SORTED = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_THRESH = 8'h68;
  localparam int               OFS_BANK0  = 'h88;
  localparam int               BANK_STRIDE = 'h20;

  localparam int CFG_SOFTRST_BIT = 1;
  localparam int ACK_BIT         = 0;
  localparam logic [7:0] THR_OPEN = 8'hFF;
  localparam logic [7:0] SRC_PRIO = 8'h00;

  typedef enum logic [1:0] {
    BK_MASK_CLR = 2'd0,
    BK_MASK_SET = 2'd1,
    BK_SW_SET   = 2'd2,
    BK_SW_CLR   = 2'd3
  } bank_op_e;

  // Byte address of one operation register of one bank
  function automatic logic [ADDR_W-1:0] bank_reg_addr(input int bank, input bank_op_e op);
    bank_reg_addr = ADDR_W'(OFS_BANK0 + bank * BANK_STRIDE + 4 * int'(op));
  endfunction

  // Threshold rule: 0xFF disables filtering, otherwise priority must be below it
  function automatic logic prio_passes(input logic [7:0] prio, input logic [7:0] thr);
    prio_passes = (thr == THR_OPEN) || (prio < thr);
  endfunction

  // Read value of the sorted-number register
  function automatic logic [DATA_W-1:0] sorted_word(input logic valid, input logic [6:0] num);
    sorted_word = valid ? DATA_W'(num) : DATA_W'(8'h80);
  endfunction

endpackage

// File: rtl/irqc_regbank.sv
module irqc_regbank
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int BANK_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] sw_q,
  output logic               rd_hit,
  output logic [DATA_W-1:0]  rd_data
);

  localparam int NUM_BANKS = NUM_SRC / BANK_W;

  logic [NUM_BANKS-1:0]             bank_hit;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_word;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_MCLR = bank_reg_addr(b, BK_MASK_CLR);
    localparam logic [ADDR_W-1:0] A_MSET = bank_reg_addr(b, BK_MASK_SET);
    localparam logic [ADDR_W-1:0] A_SSET = bank_reg_addr(b, BK_SW_SET);
    localparam logic [ADDR_W-1:0] A_SCLR = bank_reg_addr(b, BK_SW_CLR);

    logic [BANK_W-1:0] mask_r;
    logic [BANK_W-1:0] sw_r;
    logic wr_mclr, wr_mset, wr_sset, wr_sclr;
    logic [BANK_W-1:0] wbits;

    assign wbits   = wr_data[BANK_W-1:0];
    assign wr_mclr = wr_en && (addr == A_MCLR);
    assign wr_mset = wr_en && (addr == A_MSET);
    assign wr_sset = wr_en && (addr == A_SSET);
    assign wr_sclr = wr_en && (addr == A_SCLR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_r <= '1;
        sw_r   <= '0;
      end else if (clr) begin
        mask_r <= '1;
        sw_r   <= '0;
      end else begin
        if (wr_mclr) mask_r <= mask_r & ~wbits;
        if (wr_mset) mask_r <= mask_r | wbits;
        if (wr_sset) sw_r   <= sw_r | wbits;
        if (wr_sclr) sw_r   <= sw_r & ~wbits;
      end
    end

    assign mask_q[b*BANK_W +: BANK_W] = mask_r;
    assign sw_q[b*BANK_W +: BANK_W]   = sw_r;

    assign bank_hit[b]  = (addr == A_MCLR) || (addr == A_MSET) ||
                          (addr == A_SSET) || (addr == A_SCLR);
    assign bank_word[b] = ((addr == A_MCLR) || (addr == A_MSET)) ?
                          DATA_W'(mask_r) : DATA_W'(sw_r);

    // R7: bits written to the mask-set address are set afterwards
    a_r7_mask_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mset && !clr) |=> ((mask_r & $past(wbits)) == $past(wbits)));
    // R8: bits written to the software-clear address are clear afterwards
    a_r8_sw_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sclr && !clr) |=> ((sw_r & $past(wbits)) == '0));
  end

  always_comb begin
    rd_hit  = 1'b0;
    rd_data = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        rd_hit  = 1'b1;
        rd_data = bank_word[b];
      end
    end
  end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int NUM_SRC = 128,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] elig,
  output logic               found,
  output logic [ID_W-1:0]    idx
);

  // Lowest set bit wins: scan downward so the last hit is the smallest index
  function automatic logic [ID_W-1:0] lowest_idx(input logic [NUM_SRC-1:0] v);
    lowest_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) lowest_idx = ID_W'(i);
    end
  endfunction

  assign found = |elig;
  assign idx   = lowest_idx(elig);

  // R4: the reported winner is itself eligible
  a_r4_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> elig[idx]);
  // R4: no eligible source sits below the winner
  a_r4_none_below: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((elig & ~({NUM_SRC{1'b1}} << idx)) == '0));

endmodule

// File: rtl/irqc_seq.sv
module irqc_seq #(
  parameter int ID_W    = 7,
  parameter int RST_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_go,
  input  logic            ack,
  input  logic            cand_valid,
  input  logic [ID_W-1:0] cand_idx,
  output logic            soft_active,
  output logic            soft_clr,
  output logic            busy,
  output logic [ID_W-1:0] sorted_q,
  output logic            sel_evt
);

  localparam int CNT_W = $clog2(RST_CYC + 1);

  logic [CNT_W-1:0] rst_cnt;

  assign soft_active = (rst_cnt != '0);
  assign soft_clr    = soft_go || soft_active;
  assign sel_evt     = !soft_clr && !ack && !busy && cand_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rst_cnt <= '0;
    else if (soft_go)        rst_cnt <= CNT_W'(RST_CYC);
    else if (soft_active)    rst_cnt <= rst_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sorted_q <= '0;
    end else if (soft_clr || ack) begin
      busy     <= 1'b0;
    end else if (sel_evt) begin
      busy     <= 1'b1;
      sorted_q <= cand_idx;
    end
  end

  // R5: an outstanding selection holds until released
  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack && !soft_clr) |=> (busy && $stable(sorted_q)));
  // R10: the soft reset counter only runs downward once started
  a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_active && !soft_go) |=> (rst_cnt == $past(rst_cnt) - 1'b1));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC   = 128,
  parameter int BANK_W    = 32,
  parameter int RST_CYC   = 4,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [7:0]         reg_addr,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_out
);

  localparam int ID_W = $clog2(NUM_SRC);

  logic               soft_go, soft_active, soft_clr, ack_evt, wr_ok;
  logic [NUM_SRC-1:0] mask_q, sw_q, pending, elig;
  logic               bank_rd_hit, found, thr_ok, busy, sel_evt;
  logic [DATA_W-1:0]  bank_rd;
  logic [ID_W-1:0]    win_idx, sorted_q;
  logic [7:0]         thr_q;

  assign wr_ok   = reg_we && !soft_active;
  assign soft_go = wr_ok && (reg_addr == OFS_CFG) && reg_wdata[CFG_SOFTRST_BIT];
  assign ack_evt = wr_ok && (reg_addr == OFS_ACK) && reg_wdata[ACK_BIT];

  irqc_regbank #(.NUM_SRC(NUM_SRC), .BANK_W(BANK_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_clr),
    .wr_en   (wr_ok),
    .addr    (reg_addr),
    .wr_data (reg_wdata),
    .mask_q  (mask_q),
    .sw_q    (sw_q),
    .rd_hit  (bank_rd_hit),
    .rd_data (bank_rd)
  );

  assign pending = irq_src | sw_q;
  assign elig    = pending & ~mask_q;

  irqc_pick #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig),
    .found (found),
    .idx   (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    thr_q <= THR_OPEN;
    else if (soft_clr)                             thr_q <= THR_OPEN;
    else if (wr_ok && (reg_addr == OFS_THRESH))    thr_q <= reg_wdata[7:0];
  end

  assign thr_ok = prio_passes(SRC_PRIO, thr_q);

  irqc_seq #(.ID_W(ID_W), .RST_CYC(RST_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_go     (soft_go),
    .ack         (ack_evt),
    .cand_valid  (found && thr_ok),
    .cand_idx    (win_idx),
    .soft_active (soft_active),
    .soft_clr    (soft_clr),
    .busy        (busy),
    .sorted_q    (sorted_q),
    .sel_evt     (sel_evt)
  );

  assign irq_out = busy;

  always_comb begin
    unique case (reg_addr)
      OFS_REV:    reg_rdata = DATA_W'({4'(REV_MAJOR), 4'(REV_MINOR)});
      OFS_CFG:    reg_rdata = DATA_W'({soft_active, 1'b0});
      OFS_STAT:   reg_rdata = DATA_W'(!soft_active);
      OFS_SORTED: reg_rdata = sorted_word(busy, 7'(sorted_q));
      OFS_THRESH: reg_rdata = DATA_W'(thr_q);
      default:    reg_rdata = bank_rd_hit ? bank_rd : '0;
    endcase
  end

  // R6: an acknowledge drops the request on the following cycle
  a_r6_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> !irq_out);
  // R10: no request is presented while the soft reset runs
  a_r10_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_active |-> !irq_out);
  // R9: a zero threshold keeps an idle request line idle
  a_r9_zero_thr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr_q == 8'h00) && !irq_out) |=> !irq_out);
  // R3: a new request is only raised for an eligible source
  a_r3_select_needs_elig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(found));

endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;

  typedef struct {
    bit          on_irq;
    logic [31:0] exp;
    string       req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src = '0;
  logic [7:0]   reg_addr = '0;
  logic         reg_we = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         irq_out;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (src),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  // Monitor: samples one time unit after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.on_irq ? {31'b0, irq_out} : reg_rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_errors++;
          $display("FAIL %s: %s actual=0x%08h expected=0x%08h", it.req,
                   it.on_irq ? "irq_out" : "reg_rdata", act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_we    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string req);
    exp_t it;
    @(negedge clk);
    reg_addr = a;
    it.on_irq = 1'b0; it.exp = e; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic chk_irq(input logic e, input string req);
    exp_t it;
    @(negedge clk);
    it.on_irq = 1'b1; it.exp = {31'b0, e}; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;

    // Reset state
    chk_rd(8'h00, 32'h0000_0021, "R1");
    chk_rd(8'h14, 32'h1, "R10");
    chk_rd(8'h8C, 32'hFFFF_FFFF, "R2");
    chk_rd(8'hEC, 32'hFFFF_FFFF, "R2");
    chk_rd(8'h90, 32'h0, "R2");
    chk_rd(8'h68, 32'hFF, "R2");
    chk_rd(8'h40, 32'h80, "R6");
    chk_irq(1'b0, "R2");

    // Masked line does nothing
    src[5] = 1'b1;
    idle(2);
    chk_irq(1'b0, "R3");

    // Unmask source 5
    wr(8'h88, 32'h1 << 5);
    chk_irq(1'b1, "R4");
    chk_rd(8'h40, 32'd5, "R4");
    chk_rd(8'h88, 32'hFFFF_FFDF, "R7");

    // Freeze: drop 5, raise 3, unmask 3
    src[5] = 1'b0;
    src[3] = 1'b1;
    idle(2);
    chk_rd(8'h40, 32'd5, "R5");
    wr(8'h88, 32'h1 << 3);
    chk_rd(8'h40, 32'd5, "R5");
    chk_irq(1'b1, "R5");

    // Acknowledge: 3 is next
    wr(8'h48, 32'h1);
    chk_rd(8'h40, 32'd3, "R6");
    src[3] = 1'b0;
    wr(8'h48, 32'h1);
    chk_rd(8'h40, 32'h80, "R6");
    chk_irq(1'b0, "R6");

    // Threshold zero holds off, lowest wins across banks
    wr(8'h68, 32'h0);
    src[3] = 1'b1; src[70] = 1'b1; src[100] = 1'b1;
    wr(8'hC8, 32'h1 << 6);
    wr(8'hE8, 32'h1 << 4);
    chk_irq(1'b0, "R9");
    chk_rd(8'h68, 32'h0, "R9");
    wr(8'h68, 32'h5);
    chk_rd(8'h40, 32'd3, "R4");
    src[3] = 1'b0;
    wr(8'h48, 32'h1);
    chk_rd(8'h40, 32'd70, "R4");
    src[70] = 1'b0;
    wr(8'h48, 32'h1);
    chk_rd(8'h40, 32'd100, "R4");
    src[100] = 1'b0;
    wr(8'h48, 32'h1);
    chk_rd(8'h40, 32'h80, "R6");

    // Software bits
    wr(8'hF0, 32'h2);
    chk_rd(8'hF0, 32'h2, "R8");
    chk_irq(1'b0, "R3");
    wr(8'hE8, 32'h2);
    chk_rd(8'h40, 32'd97, "R3");
    chk_rd(8'hE8, 32'hFFFF_FFED, "R7");
    wr(8'hF4, 32'h2);
    chk_rd(8'hF4, 32'h0, "R8");
    chk_rd(8'h40, 32'd97, "R5");
    wr(8'h48, 32'h1);
    chk_rd(8'h40, 32'h80, "R6");

    // Mask set
    wr(8'hCC, 32'h1 << 6);
    src[70] = 1'b1;
    idle(2);
    chk_irq(1'b0, "R7");
    chk_rd(8'hC8, 32'hFFFF_FFFF, "R7");
    src[70] = 1'b0;

    // Config write without reset bit, zero mask write
    wr(8'h10, 32'h1);
    chk_rd(8'h88, 32'hFFFF_FFD7, "R11");
    chk_rd(8'h14, 32'h1, "R11");
    wr(8'h88, 32'h0);
    chk_rd(8'h8C, 32'hFFFF_FFD7, "R7");

    // Soft reset with an outstanding request and a racing write
    src[3] = 1'b1;
    wr(8'hF0, 32'h2);
    chk_rd(8'h40, 32'd3, "R4");
    wr(8'h10, 32'h2);
    wr(8'h68, 32'h0);
    chk_rd(8'h14, 32'h0, "R10");
    chk_irq(1'b0, "R10");
    idle(4);
    chk_rd(8'h14, 32'h1, "R10");
    chk_rd(8'h10, 32'h0, "R10");
    chk_rd(8'h88, 32'hFFFF_FFFF, "R10");
    chk_rd(8'hE8, 32'hFFFF_FFFF, "R10");
    chk_rd(8'hF0, 32'h0, "R10");
    chk_rd(8'h68, 32'hFF, "R10");
    chk_rd(8'h40, 32'h80, "R10");
    chk_irq(1'b0, "R10");
    src[3] = 1'b0;

    idle(3);
    if (sb_q.size() != 0) begin
      n_errors++;
      $display("FAIL scoreboard: actual=%0d left expected=0 left", sb_q.size());
    end
    finish_run();
  end

endmodule